// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Open-Row Buffer

This block is a synchronous controller that connects a CPU-side request port to a small storage array modelled inside the design. The array is a square grid of cells. A cell is named by a row index and a column index. Each request reads or writes one cell. The external address bus is only as wide as one index, so the controller sends the row index and the column index over it in two separate cycles. A row strobe marks the cycle that carries the row, and a column strobe marks the cycle that carries the column.

A row strobe copies the whole row into an internal row buffer and leaves that row open. Reads and writes then work on the buffer. A later request to the same open row needs only a column strobe. A request to a different row first runs a precharge phase of fixed length. The precharge writes the buffer back into the array, and only then is the new row strobed.

An internal counter schedules a refresh before a fixed number of cycles has passed. A pending refresh wins over a new request, but it never breaks into an access that has already started. Every refresh closes the open row.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After reset the block shows the following state.
  - `req_ready` is 1.
  - `row_stb`, `col_stb`, `refresh_stb` and `rdata_valid` are 0.
  - No row is open.
  - Every cell reads back as 0.
- R2: The two strobes and the address bus work together as follows.
  - While `row_stb` is 1, `mem_addr` carries the requested row index.
  - While `col_stb` is 1, `mem_addr` carries the requested column index.
  - Each row strobe is followed in the very next cycle by a column strobe.
  - At most one of `row_stb`, `col_stb` and `refresh_stb` is 1 in any cycle.
- R3: A read returns data through `rdata`, as follows.
  - `rdata` equals the last value written to that cell (read-after-write).
  - `rdata_valid` pulses for exactly one cycle, one cycle after the column strobe.
- R4: An open-row hit is a request whose row equals the open row.
  - It produces no row strobe.
  - Its column strobe is in cycle 1 after the acceptance edge.
  - For a read, `rdata_valid` is in cycle 2.
- R5: A request made while no row is open works as follows.
  - The row strobe is in cycle 1 after acceptance.
  - The column strobe is in cycle 2.
  - For a read, `rdata_valid` is in cycle 3.
- R6: A request to a row other than the open one works as follows.
  - First comes a precharge of PRE_CYCLES cycles with no strobe.
  - The row strobe is in cycle PRE_CYCLES+1 and the column strobe in cycle PRE_CYCLES+2.
  - For a read, `rdata_valid` is in cycle PRE_CYCLES+3.
  - Data written into the old row survives.
- R7: A write updates the addressed cell and never raises `rdata_valid`.
- R8: `refresh_stb` is asserted at most REFRESH_CYCLES cycles after reset, and at most REFRESH_CYCLES cycles after the previous refresh.
- R9: Refresh never interrupts a started access. A refresh closes the open row, so the next access needs a row strobe. Stored data survives refresh.
- R10: A request is taken only at a rising edge where both `req_valid` and `req_ready` are 1. `req_ready` stays 0 from the acceptance edge until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | IDX_W | Row index of the target cell |
| req_col | input | IDX_W | Column index of the target cell |
| req_wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| rdata_valid | output | 1 | One-cycle pulse qualifying `rdata` |
| mem_addr | output | IDX_W | Shared row/column address bus |
| row_stb | output | 1 | Row strobe: row activation this cycle |
| col_stb | output | 1 | Column strobe: cell access this cycle |
| refresh_stb | output | 1 | Refresh cycle |

## Verification
Cycles are counted from the rising edge that accepts a request. An access strobes the row and the column in fixed cycles after that edge, and for a read `rdata_valid` also follows a fixed count:

| Request kind | Row strobe | Column strobe | `rdata_valid` |
|---|---|---|---|
| Open-row hit | none | 1 | 2 |
| No row open | 1 | 2 | 3 |
| Different row open | PRE_CYCLES+1 | PRE_CYCLES+2 | PRE_CYCLES+3 |

The bench decides which of the three cases applies just before the request is accepted. It keeps a model of the open row, built from the row strobes it has seen and cleared on every refresh strobe. It samples each cycle on the falling edge and checks that each strobe, the address value and the data pulse appear exactly in the expected cycle, and in no other. Refresh spacing is measured in cycles by a separate monitor that runs for the whole test.

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl #(
  parameter int IDX_W          = 2,
  parameter int DATA_W         = 8,
  parameter int PRE_CYCLES     = 2,
  parameter int REFRESH_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_row,
  input  logic [IDX_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [IDX_W-1:0]  mem_addr,
  output logic              row_stb,
  output logic              col_stb,
  output logic              refresh_stb
);

  localparam int GRID      = 1 << IDX_W;
  localparam int CELLS     = GRID * GRID;
  localparam int SLACK     = 2 * PRE_CYCLES + 4;
  localparam int REF_START = REFRESH_CYCLES - SLACK;
  localparam int CNT_W     = $clog2(REFRESH_CYCLES + 1);
  localparam int PC_W      = $clog2(PRE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_COL, S_REF} state_t;

  state_t st;
  logic [DATA_W-1:0] cells  [CELLS];
  logic [DATA_W-1:0] rowbuf [GRID];
  logic              open_vld;
  logic [IDX_W-1:0]  open_row;
  logic [PC_W-1:0]   pre_cnt;
  logic [CNT_W-1:0]  ref_cnt;
  logic              pre_to_ref;
  logic              q_write;
  logic [IDX_W-1:0]  q_row, q_col;
  logic [DATA_W-1:0] q_wdata;
  logic              ref_pend, accept, hit;

  assign ref_pend    = ref_cnt >= CNT_W'(REF_START);
  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign accept      = req_valid && req_ready;
  assign hit         = open_vld && (open_row == req_row);
  assign row_stb     = (st == S_ACT);
  assign col_stb     = (st == S_COL);
  assign refresh_stb = (st == S_REF);
  assign mem_addr    = row_stb ? q_row : (col_stb ? q_col : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      open_vld    <= 1'b0;
      open_row    <= '0;
      pre_cnt     <= '0;
      pre_to_ref  <= 1'b0;
      q_write     <= 1'b0;
      q_row       <= '0;
      q_col       <= '0;
      q_wdata     <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      for (int i = 0; i < CELLS; i++) cells[i] <= '0;
      for (int j = 0; j < GRID; j++) rowbuf[j] <= '0;
    end else begin
      rdata_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (ref_pend) begin
            pre_to_ref <= 1'b1;
            pre_cnt    <= PC_W'(PRE_CYCLES - 1);
            st         <= open_vld ? S_PRE : S_REF;
          end else if (accept) begin
            q_write    <= req_write;
            q_row      <= req_row;
            q_col      <= req_col;
            q_wdata    <= req_wdata;
            pre_to_ref <= 1'b0;
            pre_cnt    <= PC_W'(PRE_CYCLES - 1);
            if (hit)           st <= S_COL;
            else if (open_vld) st <= S_PRE;
            else               st <= S_ACT;
          end
        end
        S_PRE: begin
          if (pre_cnt == '0) begin
            for (int j = 0; j < GRID; j++) cells[{open_row, IDX_W'(j)}] <= rowbuf[j];
            open_vld <= 1'b0;
            st       <= pre_to_ref ? S_REF : S_ACT;
          end else begin
            pre_cnt <= pre_cnt - 1'b1;
          end
        end
        S_ACT: begin
          for (int j = 0; j < GRID; j++) rowbuf[j] <= cells[{q_row, IDX_W'(j)}];
          open_row <= q_row;
          open_vld <= 1'b1;
          st       <= S_COL;
        end
        S_COL: begin
          if (q_write) begin
            rowbuf[q_col] <= q_wdata;
          end else begin
            rdata       <= rowbuf[q_col];
            rdata_valid <= 1'b1;
          end
          st <= S_IDLE;
        end
        S_REF: begin
          open_vld <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ref_cnt <= '0;
    else if (st == S_REF)   ref_cnt <= '0;
    else                    ref_cnt <= ref_cnt + 1'b1;
  end

  p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({row_stb, col_stb, refresh_stb}));

  p_row_then_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> col_stb);

  p_valid_after_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(col_stb));

  p_hit_no_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (col_stb && !row_stb));

  p_refresh_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt < CNT_W'(REFRESH_CYCLES));

  p_busy_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: tb/test_mux_dram_ctrl.sv
module test_mux_dram_ctrl;
  localparam int IW  = 2;
  localparam int DW  = 8;
  localparam int PRE = 2;
  localparam int REF = 60;
  localparam int G   = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [IW-1:0] req_row = '0, req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rdata_valid, row_stb, col_stb, refresh_stb;
  logic [DW-1:0] rdata;
  logic [IW-1:0] mem_addr;

  mux_dram_ctrl #(.IDX_W(IW), .DATA_W(DW), .PRE_CYCLES(PRE), .REFRESH_CYCLES(REF)) i_mux_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
    .row_stb(row_stb), .col_stb(col_stb), .refresh_stb(refresh_stb));

  int checks = 0, errors = 0, gap = 0;
  bit done = 0, mvld = 0;
  logic [IW-1:0] mrow = '0;
  logic [DW-1:0] shadow [G*G];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int c, input int salt);
    return DW'((r * 37 + c * 11 + salt * 71 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      gap++;
      if (refresh_stb) begin
        chk(gap <= REF, "R8", "refresh spacing", gap, REF);
        gap = 0;
        mvld = 0;
      end else if (gap > REF) begin
        chk(1'b0, "R8", "refresh overdue", gap, REF);
        gap = 0;
      end
    end
  end

  task automatic access(input bit wr, input int r, input int c, input logic [DW-1:0] d, input string dtag);
    bit hit, conf;
    int v, nrow, nval;
    req_valid = 1'b1; req_write = wr; req_row = IW'(r); req_col = IW'(c); req_wdata = d;
    while (!req_ready) @(negedge clk);
    hit  = mvld && (mrow == IW'(r));
    conf = mvld && !hit;
    v    = hit ? 2 : (conf ? PRE + 3 : 3);
    nrow = 0; nval = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i <= PRE + 4; i++) begin
      if (i > 1) @(negedge clk);
      if (i < v) begin
        chk(!req_ready, "R10", "ready while busy", int'(req_ready), 0);
        chk(!refresh_stb, "R9", "refresh inside access", int'(refresh_stb), 0);
      end
      if (conf && i <= PRE)
        chk(!row_stb && !col_stb, "R6", "strobe during precharge", int'({row_stb, col_stb}), 0);
      if (row_stb) begin
        nrow++;
        chk(!hit && i == v - 2, hit ? "R4" : (conf ? "R6" : "R5"), "row strobe cycle", i, v - 2);
        chk(mem_addr == IW'(r), "R2", "row address", int'(mem_addr), r);
        mvld = 1; mrow = IW'(r);
      end
      if (col_stb) begin
        chk(i == v - 1, hit ? "R4" : (conf ? "R6" : "R5"), "column strobe cycle", i, v - 1);
        chk(mem_addr == IW'(c), "R2", "column address", int'(mem_addr), c);
      end
      if (rdata_valid) begin
        nval++;
        chk(!wr && i == v, "R3", "rdata_valid cycle", i, v);
        chk(rdata == shadow[r * G + c], dtag, "read data", int'(rdata), int'(shadow[r * G + c]));
      end
    end
    chk(nrow == (hit ? 0 : 1), hit ? "R4" : "R5", "row strobe count", nrow, hit ? 0 : 1);
    if (wr) chk(nval == 0, "R7", "rdata_valid on write", nval, 0);
    else    chk(nval == 1, "R3", "rdata_valid pulses", nval, 1);
    if (wr) shadow[r * G + c] = d;
  endtask

  initial begin
    for (int i = 0; i < G * G; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !row_stb && !col_stb && !refresh_stb && !rdata_valid, "R1", "reset outputs",
        int'({req_ready, row_stb, col_stb, refresh_stb, rdata_valid}), 16);
    #2 rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < G; r++) for (int c = 0; c < G; c++) access(0, r, c, '0, "R1");
    for (int r = 0; r < G; r++) for (int c = 0; c < G; c++) access(1, r, c, pat(r, c, 0), "R7");
    for (int r = 0; r < G; r++) for (int c = 0; c < G; c++) access(0, r, c, '0, "R3");
    for (int c = 0; c < G; c++) for (int r = 0; r < G; r++) access(0, r, c, '0, "R6");
    for (int c = 0; c < G; c++) for (int r = 0; r < G; r++) begin
      access(1, r, c, pat(r, c, 1), "R7");
      access(0, r, c, '0, "R3");
    end
    for (int r = G - 1; r >= 0; r--) for (int c = 0; c < G; c++) access(0, r, c, '0, "R6");
    repeat (2 * REF + 5) @(negedge clk);
    for (int r = 0; r < G; r++) for (int c = 0; c < G; c++) access(0, r, c, '0, "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule